// File: doc/BRIEF.md
# Floating-Point Min/Max Selector

This unit returns the smaller or larger of two floating-point operands. Each operand sits in a 64-bit register that holds either a double-precision value or a single-precision value kept in the low half with the upper 32 bits forced to ones. A precision select chooses the format and a mode select chooses minimum or maximum. The order is the IEEE quiet compare in sign-magnitude form. NaN inputs follow a rule that favours numbers: if one operand is NaN, the other operand is the answer.

The result and an invalid-operation flag come out of one register stage, so the output for inputs presented at a clock edge is visible after that edge. No rounding or other arithmetic takes place. The returned value is always one of the input bit patterns or the canonical NaN of the selected precision.

Top module: `fp_minmax_unit`

## Requirements
- R1: In minimum mode (max_i=0) with both operands non-NaN, the result is operand A when A is strictly less than B, and operand B otherwise.
- R2: In maximum mode (max_i=1) with both operands non-NaN, the result is operand A when B is less than or equal to A, and operand B otherwise.
- R3: When exactly one operand is NaN and neither is signaling, the result is the non-NaN operand. A NaN has an all-ones exponent and a nonzero fraction.
- R4: When both operands are NaN, the result is the canonical NaN: 0x7FF8000000000000 in double precision, or 0xFFFFFFFF7FC00000 in single precision.
- R5: When either operand is a signaling NaN (fraction MSB equal to 0), the result is the canonical NaN and invalid_o is 1.
- R6: Quiet NaN inputs and ordinary numbers leave invalid_o at 0.
- R7: In single precision (dbl_i=0), an operand whose bits 63:32 are not all ones is read as the canonical quiet NaN. It therefore raises no flag.
- R8: Every single-precision result has bits 63:32 all ones, with the 32-bit value in bits 31:0.
- R9: +0 and -0 compare equal, as do identical values. For equal operands, minimum returns B and maximum returns A.
- R10: While rst_ni is low, res_o and invalid_o are 0. Otherwise the outputs show the result for the inputs sampled at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 64 | Operand A, boxed register value |
| op_b_i | input | 64 | Operand B, boxed register value |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision |
| max_i | input | 1 | 1 = maximum, 0 = minimum |
| res_o | output | 64 | Registered result |
| invalid_o | output | 1 | Registered invalid-operation flag |

## Verification
The properties assume the inputs are held stable across each rising edge, so the sampled precision and operands line up with the result one cycle later. The properties also assume nothing is checked on the first edge after reset. The stimulus changes inputs only on the falling edge. The stimulus mixes zeros of both signs, infinities, quiet and signaling NaNs, ordinary values and badly boxed singles in both precisions and both modes. It also holds the inputs busy during reset, so that reset dominance is seen at the outputs.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  parameter int unsigned XLEN   = 64;
  parameter int unsigned SP_EXP = 8;
  parameter int unsigned SP_MAN = 23;
  parameter int unsigned DP_EXP = 11;
  parameter int unsigned DP_MAN = 52;

  localparam int unsigned SP_W  = 1 + SP_EXP + SP_MAN;
  localparam int unsigned MAG_W = XLEN - 1;

  localparam logic [SP_W-1:0] SP_QNAN =
    {1'b0, {SP_EXP{1'b1}}, 1'b1, {(SP_MAN-1){1'b0}}};
  localparam logic [XLEN-1:0] DP_QNAN =
    {1'b0, {DP_EXP{1'b1}}, 1'b1, {(DP_MAN-1){1'b0}}};
  localparam logic [XLEN-1:0] SP_QNAN_BOXED = {{(XLEN-SP_W){1'b1}}, SP_QNAN};

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic             is_nan;
    logic             is_snan;
    logic             is_zero;
  } fpmm_opnd_t;
endpackage

// File: rtl/fpmm_unpack.sv
module fpmm_unpack
  import fpmm_pkg::*;
(
  input  logic [XLEN-1:0] raw_i,
  input  logic            dbl_i,
  output fpmm_opnd_t      opnd_o,
  output logic [XLEN-1:0] keep_o
);
  logic            box_ok;
  logic [SP_W-1:0] sp_bits;
  logic [SP_EXP-1:0] sp_exp;
  logic [SP_MAN-1:0] sp_man;
  logic [DP_EXP-1:0] dp_exp;
  logic [DP_MAN-1:0] dp_man;

  assign box_ok  = &raw_i[XLEN-1:SP_W];
  assign sp_bits = box_ok ? raw_i[SP_W-1:0] : SP_QNAN;
  assign sp_exp  = sp_bits[SP_W-2 -: SP_EXP];
  assign sp_man  = sp_bits[SP_MAN-1:0];
  assign dp_exp  = raw_i[XLEN-2 -: DP_EXP];
  assign dp_man  = raw_i[DP_MAN-1:0];

  always_comb begin
    if (dbl_i) begin
      opnd_o.sign    = raw_i[XLEN-1];
      opnd_o.mag     = raw_i[MAG_W-1:0];
      opnd_o.is_nan  = (&dp_exp) && (|dp_man);
      opnd_o.is_snan = (&dp_exp) && (|dp_man) && !dp_man[DP_MAN-1];
      keep_o         = raw_i;
    end else begin
      opnd_o.sign    = sp_bits[SP_W-1];
      opnd_o.mag     = MAG_W'(sp_bits[SP_W-2:0]);
      opnd_o.is_nan  = (&sp_exp) && (|sp_man);
      opnd_o.is_snan = (&sp_exp) && (|sp_man) && !sp_man[SP_MAN-1];
      keep_o         = {{(XLEN-SP_W){1'b1}}, sp_bits};
    end
    opnd_o.is_zero = ~|opnd_o.mag;
  end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order
  import fpmm_pkg::*;
(
  input  fpmm_opnd_t a_i,
  input  fpmm_opnd_t b_i,
  output logic       a_lt_b_o,
  output logic       b_le_a_o
);
  logic both_zero, mag_lt, mag_gt;

  assign both_zero = a_i.is_zero & b_i.is_zero;
  assign mag_lt    = a_i.mag < b_i.mag;
  assign mag_gt    = a_i.mag > b_i.mag;

  // signed zeros collapse to equality before sign inspection
  always_comb begin
    if (both_zero) begin
      a_lt_b_o = 1'b0;
      b_le_a_o = 1'b1;
    end else if (a_i.sign != b_i.sign) begin
      a_lt_b_o = a_i.sign;
      b_le_a_o = b_i.sign;
    end else if (a_i.sign) begin
      a_lt_b_o = mag_gt;
      b_le_a_o = !mag_gt;
    end else begin
      a_lt_b_o = mag_lt;
      b_le_a_o = !mag_lt;
    end
  end
endmodule

// File: rtl/fpmm_pick.sv
module fpmm_pick
  import fpmm_pkg::*;
(
  input  fpmm_opnd_t      a_i,
  input  fpmm_opnd_t      b_i,
  input  logic [XLEN-1:0] keep_a_i,
  input  logic [XLEN-1:0] keep_b_i,
  input  logic            a_lt_b_i,
  input  logic            b_le_a_i,
  input  logic            dbl_i,
  input  logic            max_i,
  output logic [XLEN-1:0] res_o,
  output logic            invalid_o
);
  logic ordered, take_a, canon;

  assign ordered   = !a_i.is_nan && !b_i.is_nan;
  assign take_a    = b_i.is_nan || (ordered && (max_i ? b_le_a_i : a_lt_b_i));
  assign invalid_o = a_i.is_snan | b_i.is_snan;
  assign canon     = (a_i.is_nan & b_i.is_nan) | invalid_o;

  always_comb begin
    if (canon)       res_o = dbl_i ? DP_QNAN : SP_QNAN_BOXED;
    else if (take_a) res_o = keep_a_i;
    else             res_o = keep_b_i;
  end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
  import fpmm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] op_a_i,
  input  logic [XLEN-1:0] op_b_i,
  input  logic            dbl_i,
  input  logic            max_i,
  output logic [XLEN-1:0] res_o,
  output logic            invalid_o
);
  localparam int unsigned NOPS = 2;

  logic [XLEN-1:0] raw  [NOPS];
  logic [XLEN-1:0] keep [NOPS];
  fpmm_opnd_t      opnd [NOPS];
  logic            a_lt_b, b_le_a;
  logic [XLEN-1:0] res_d;
  logic            inv_d;

  assign raw[0] = op_a_i;
  assign raw[1] = op_b_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_unpack
    fpmm_unpack u_unpack (
      .raw_i  (raw[g]),
      .dbl_i  (dbl_i),
      .opnd_o (opnd[g]),
      .keep_o (keep[g])
    );
  end

  fpmm_order u_order (
    .a_i      (opnd[0]),
    .b_i      (opnd[1]),
    .a_lt_b_o (a_lt_b),
    .b_le_a_o (b_le_a)
  );

  fpmm_pick u_pick (
    .a_i       (opnd[0]),
    .b_i       (opnd[1]),
    .keep_a_i  (keep[0]),
    .keep_b_i  (keep[1]),
    .a_lt_b_i  (a_lt_b),
    .b_le_a_i  (b_le_a),
    .dbl_i     (dbl_i),
    .max_i     (max_i),
    .res_o     (res_d),
    .invalid_o (inv_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      invalid_o <= 1'b0;
    end else begin
      res_o     <= res_d;
      invalid_o <= inv_d;
    end
  end
endmodule

// File: rtl/fpmm_chk.sv
module fpmm_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [63:0] op_a_i,
  input logic [63:0] op_b_i,
  input logic        dbl_i,
  input logic        max_i,
  input logic [63:0] res_o,
  input logic        invalid_o
);
  localparam logic [63:0] DQ = 64'h7FF8000000000000;
  localparam logic [63:0] SQ = 64'hFFFFFFFF7FC00000;

  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  function automatic logic d_nan(input logic [63:0] v);
    return (&v[62:52]) && (|v[51:0]);
  endfunction
  function automatic logic d_snan(input logic [63:0] v);
    return d_nan(v) && !v[51];
  endfunction
  function automatic logic s_snan(input logic [63:0] v);
    return (v[63:32] == 32'hFFFFFFFF) && (&v[30:23]) && (|v[22:0]) && !v[22];
  endfunction

  logic any_snan, dp_both_nan;
  assign any_snan    = dbl_i ? (d_snan(op_a_i) || d_snan(op_b_i))
                             : (s_snan(op_a_i) || s_snan(op_b_i));
  assign dp_both_nan = dbl_i && d_nan(op_a_i) && d_nan(op_b_i);

  // R5
  canon_on_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && invalid_o |-> res_o == ($past(dbl_i) ? DQ : SQ));
  // R6
  flag_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed |-> invalid_o == $past(any_snan));
  // R8
  single_box_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && !$past(dbl_i) |-> res_o[63:32] == 32'hFFFFFFFF);
  // R3
  dp_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(dbl_i) |->
      (res_o == $past(op_a_i) || res_o == $past(op_b_i) || res_o == DQ));
  // R4
  dp_both_nan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(dp_both_nan) |-> res_o == DQ);
endmodule

bind fp_minmax_unit fpmm_chk u_chk (.*);

// File: tb/fp_minmax_unit_bench.sv
`timescale 1ns/1ps
module fp_minmax_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic        dbl = 1'b0, mx = 1'b0;
  logic [63:0] res;
  logic        inv;

  int checks = 0;
  int fails  = 0;
  bit pend = 0;
  bit done = 0;
  logic [63:0] pa, pb;
  logic        pd, pm;

  always #4 clk = ~clk;

  fp_minmax_unit u_fp_minmax_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(a), .op_b_i(b),
    .dbl_i(dbl), .max_i(mx), .res_o(res), .invalid_o(inv)
  );

  function automatic void model(input logic [63:0] ra, input logic [63:0] rb,
                                input bit d, input bit m,
                                output logic [63:0] er, output bit ei, output string tag);
    logic [63:0] va, vb;
    bit na, nb, sa, sb, badbox, pick_a;
    longint ka, kb;
    badbox = 0;
    if (d) begin
      va = ra; vb = rb;
      na = (va[62:52] == 11'h7FF) && (va[51:0] != 0);
      nb = (vb[62:52] == 11'h7FF) && (vb[51:0] != 0);
      sa = na && !va[51]; sb = nb && !vb[51];
      ka = va[63] ? -longint'(va[62:0]) : longint'(va[62:0]);
      kb = vb[63] ? -longint'(vb[62:0]) : longint'(vb[62:0]);
    end else begin
      badbox = (ra[63:32] != 32'hFFFFFFFF) || (rb[63:32] != 32'hFFFFFFFF);
      va = {32'hFFFFFFFF, (ra[63:32] == 32'hFFFFFFFF) ? ra[31:0] : 32'h7FC00000};
      vb = {32'hFFFFFFFF, (rb[63:32] == 32'hFFFFFFFF) ? rb[31:0] : 32'h7FC00000};
      na = (va[30:23] == 8'hFF) && (va[22:0] != 0);
      nb = (vb[30:23] == 8'hFF) && (vb[22:0] != 0);
      sa = na && !va[22]; sb = nb && !vb[22];
      ka = va[31] ? -longint'(va[30:0]) : longint'(va[30:0]);
      kb = vb[31] ? -longint'(vb[30:0]) : longint'(vb[30:0]);
    end
    if (m) pick_a = nb || (!na && kb <= ka);
    else   pick_a = nb || (!na && ka < kb);
    ei = sa || sb;
    if (ei || (na && nb)) er = d ? 64'h7FF8000000000000 : 64'hFFFFFFFF7FC00000;
    else                  er = pick_a ? va : vb;
    if (ei)              tag = "R5";
    else if (badbox)     tag = "R7";
    else if (na && nb)   tag = "R4";
    else if (na || nb)   tag = "R3";
    else if (ka == kb)   tag = "R9";
    else                 tag = m ? "R2" : "R1";
  endfunction

  task automatic check_pending();
    logic [63:0] er; bit ei; string tag;
    if (!pend) return;
    model(pa, pb, pd, pm, er, ei, tag);
    checks++;
    if (res !== er) begin
      fails++;
      $display("FAIL %s (R10 latency) res a=%h b=%h dbl=%0b max=%0b: got %h exp %h",
               tag, pa, pb, pd, pm, res, er);
    end
    checks++;
    if (inv !== ei) begin
      fails++;
      $display("FAIL %s flag: got %0b exp %0b", ei ? "R5" : "R6", inv, ei);
    end
    if (!pd) begin
      checks++;
      if (res[63:32] !== 32'hFFFFFFFF) begin
        fails++;
        $display("FAIL R8 box: got %h exp ffffffff", res[63:32]);
      end
    end
  endtask

  task automatic apply(input logic [63:0] x, input logic [63:0] y, input bit d, input bit m);
    @(negedge clk);
    check_pending();
    a = x; b = y; dbl = d; mx = m;
    pa = x; pb = y; pd = d; pm = m; pend = 1;
  endtask

  function automatic logic [63:0] gen(input bit d);
    int k = $urandom_range(0, 8);
    logic [63:0] r = {$urandom, $urandom};
    logic [63:0] v;
    if (d) begin
      case (k)
        0: v = 64'h0;
        1: v = 64'h8000000000000000;
        2: v = {r[63], 11'h7FF, 52'h0};
        3: v = {r[63], 11'h7FF, 1'b1, r[50:0]};
        4: v = {r[63], 11'h7FF, 1'b0, r[50:1], 1'b1};
        5: v = {r[63], 11'h3FF, 47'h0, r[4:0]};
        default: v = r;
      endcase
    end else begin
      case (k)
        0: v = {32'hFFFFFFFF, 32'h0};
        1: v = {32'hFFFFFFFF, 32'h80000000};
        2: v = {32'hFFFFFFFF, r[31], 8'hFF, 23'h0};
        3: v = {32'hFFFFFFFF, r[31], 8'hFF, 1'b1, r[21:0]};
        4: v = {32'hFFFFFFFF, r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
        5: v = {32'hFFFFFFFF, r[31], 8'h7F, 20'h0, r[2:0]};
        6: v = r;
        default: v = {32'hFFFFFFFF, r[31:0]};
      endcase
    end
    return v;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R10: got hung run exp completion");
      finish_run();
    end
  end

  initial begin
    // R10: reset holds outputs low even with live inputs
    repeat (2) @(negedge clk);
    a = 64'h3FF0000000000000; b = 64'h4000000000000000; dbl = 1;
    @(negedge clk);
    checks++;
    if (res !== 64'h0 || inv !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: got %h/%0b exp 0/0", res, inv);
    end
    rst_n = 1'b1;

    // R1/R2 double
    apply(64'h3FF0000000000000, 64'h4000000000000000, 1, 0);
    apply(64'h3FF0000000000000, 64'h4000000000000000, 1, 1);
    apply(64'hC008000000000000, 64'h3FF0000000000000, 1, 0);
    apply(64'hC008000000000000, 64'hBFF0000000000000, 1, 1);
    // R9 signed zeros and equal values
    apply(64'h0000000000000000, 64'h8000000000000000, 1, 0);
    apply(64'h0000000000000000, 64'h8000000000000000, 1, 1);
    apply(64'hFFFFFFFF80000000, 64'hFFFFFFFF00000000, 0, 0);
    apply(64'hFFFFFFFF3F800000, 64'hFFFFFFFF3F800000, 0, 1);
    // R3 one quiet NaN
    apply(64'h7FF8000000000001, 64'h4000000000000000, 1, 0);
    apply(64'h3FF0000000000000, 64'hFFF8000000000000, 1, 1);
    // R4 both NaN
    apply(64'h7FF8000000000123, 64'hFFF8000000000000, 1, 0);
    apply(64'hFFFFFFFF7FC00001, 64'hFFFFFFFFFFC00000, 0, 1);
    // R5 signaling
    apply(64'h7FF0000000000001, 64'h3FF0000000000000, 1, 0);
    apply(64'hFFFFFFFF3F800000, 64'hFFFFFFFF7F800001, 0, 1);
    // R7 bad box with single values, R8 boxing
    apply(64'h000000003F800000, 64'hFFFFFFFF40000000, 0, 0);
    apply(64'h0000000000000000, 64'h1234567800000000, 0, 1);
    apply(64'hFFFFFFFF3F800000, 64'hFFFFFFFF40000000, 0, 0);
    apply(64'hFFFFFFFFBFC00000, 64'hFFFFFFFF3F800000, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      bit d = 1'($urandom);
      apply(gen(d), gen(d), d, 1'($urandom));
    end
    @(negedge clk);
    check_pending();
    pend = 0;
    done = 1;
    finish_run();
  end
endmodule